// File: doc/BRIEF.md
# Framed Start-Pulse and Data Pattern Generator

This block is a synthesizable stimulus sequencer. A request on `go`, sampled while the block is idle, launches one frame of a fixed number of cycles (64 by default). The first cycle of the frame carries a one-cycle `start` strobe. The `data` word then follows a fixed high/low/high window: all ones early in the frame, zero across a middle window, and all ones again up to the last index. One cycle after the last index, `done` pulses, and the block falls back to idle until it sees the next request.

The frame position is held in a single counter. Two decoders, one for the strobes and one for the data window, turn that position into outputs. The decoders work on the counter's next value, and every output is taken from a flip-flop. A consumer clocked on the same edge therefore always sees values that were settled a full cycle earlier. A downstream design under test can use the generator as a repeatable frame source: hold `go` high for back-to-back frames, or pulse it once per frame.

Top module: `frame_pattern_gen`

## Requirements
- R1: `rst` is synchronous and active high. At the first rising edge where it is sampled high, it returns the block to idle, whatever phase it was in. After that edge `start`, `data` and `done` are all 0.
- R2: While idle with `go` low, `start` and `done` stay 0 and `data` stays 0.
- R3: When `go` is sampled high at a rising edge while idle, the next cycle is frame index 0. In that cycle `start` is 1 for exactly one cycle and `data` is 0.
- R4: For frame indices 1 to 23, `data` is all ones (255 for the default 8-bit width).
- R5: For frame indices 24 to 40 inclusive, `data` is 0.
- R6: For frame indices 41 to 63, `data` is all ones.
- R7: In the cycle after index 63, `done` is 1 for exactly one cycle while `start` and `data` are 0. The block is idle from the cycle after that.
- R8: `go` is ignored while a frame runs and during the `done` cycle. Such a request neither restarts nor extends the frame, and it does not queue a new one.
- R9: With `go` held high, frames repeat back to back, and consecutive `start` pulses are 66 cycles apart: 64 frame cycles, the `done` cycle and one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Frame request, sampled only while idle |
| start | output | 1 | One-cycle strobe at frame index 0 |
| data | output | DATA_W | Windowed pattern word |
| done | output | 1 | One-cycle pulse after the last frame index |

## Verification
The hardest cases to reach are the cycle boundaries at the end of a frame: a request that lands in the `done` cycle, and one that arrives in the very first idle cycle after it. Both can be mistaken for a fresh start. The stimulus times `go` to the half cycle against a position counted from the observed `start`. It pulses `go` in the middle of a frame and inside the `done` cycle, then checks that no strobe follows. In a separate test it holds `go` high across two frames to confirm the 66-cycle spacing. A reset in the middle of a frame is also driven, to show that the abort is immediate.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } phase_t;
endpackage

// File: rtl/fpg_seq.sv
// Frame position sequencer: phase plus index, with next-value outputs.
module fpg_seq
   import fpg_pkg::*;
#(
   parameter int FRAME_LEN = 64,
   localparam int IDX_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             go,
   output phase_t           nxt_phase,
   output logic [IDX_W-1:0] nxt_idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   phase_t           cur_phase;
   logic [IDX_W-1:0] cur_idx;

   always_comb begin
      nxt_phase = cur_phase;
      nxt_idx   = cur_idx;
      if (rst) begin
         nxt_phase = PH_IDLE;
         nxt_idx   = '0;
      end else begin
         unique case (cur_phase)
            PH_IDLE: begin
               if (go) begin
                  nxt_phase = PH_RUN;
                  nxt_idx   = '0;
               end
            end
            PH_RUN: begin
               if (cur_idx == LAST_IDX) begin
                  nxt_phase = PH_DONE;
                  nxt_idx   = '0;
               end else begin
                  nxt_idx = cur_idx + 1'b1;
               end
            end
            PH_DONE: begin
               nxt_phase = PH_IDLE;
               nxt_idx   = '0;
            end
            default: begin
               nxt_phase = PH_IDLE;
               nxt_idx   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      cur_phase <= nxt_phase;
      cur_idx   <= nxt_idx;
   end
endmodule

// File: rtl/fpg_decode.sv
// Position decoders: strobe decoder and data window decoder.
module fpg_decode
   import fpg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int FRAME_LEN = 64,
   parameter int LO_FIRST  = 24,
   parameter int LO_LAST   = 40,
   localparam int IDX_W    = $clog2(FRAME_LEN)
) (
   input  phase_t            phase,
   input  logic [IDX_W-1:0]  idx,
   output logic              start_d,
   output logic              done_d,
   output logic [DATA_W-1:0] data_d
);
   localparam logic [IDX_W-1:0] WIN_LO = IDX_W'(LO_FIRST);
   localparam logic [IDX_W-1:0] WIN_HI = IDX_W'(LO_LAST);

   logic in_run;
   logic at_head;
   logic in_window;
   logic drive_high;

   // strobe decoder
   always_comb begin
      in_run  = (phase == PH_RUN);
      at_head = (idx == '0);
      start_d = in_run && at_head;
      done_d  = (phase == PH_DONE);
   end

   // data window decoder
   always_comb begin
      in_window  = (idx >= WIN_LO) && (idx <= WIN_HI);
      drive_high = in_run && !at_head && !in_window;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign data_d[b] = drive_high;
   end
endmodule

// File: rtl/fpg_outreg.sv
// Output flops: every port of the block leaves from a register.
module fpg_outreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_d,
   input  logic              done_d,
   input  logic [DATA_W-1:0] data_d,
   output logic              start_q,
   output logic              done_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         start_q <= start_d;
         done_q  <= done_d;
         data_q  <= data_d;
      end
   end
endmodule

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen
   import fpg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int FRAME_LEN = 64,
   parameter int LO_FIRST  = 24,
   parameter int LO_LAST   = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   output logic              start,
   output logic [DATA_W-1:0] data,
   output logic              done
);
   localparam int IDX_W = $clog2(FRAME_LEN);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (FRAME_LEN < 4) begin : g_bad_len
      $error("FRAME_LEN must be at least 4");
   end
   if (LO_FIRST < 2 || LO_LAST < LO_FIRST || LO_LAST > FRAME_LEN - 2) begin : g_bad_win
      $error("low window must lie strictly inside the frame");
   end

   phase_t            nxt_phase;
   logic [IDX_W-1:0]  nxt_idx;
   logic              start_d;
   logic              done_d;
   logic [DATA_W-1:0] data_d;

   fpg_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .go        (go),
      .nxt_phase (nxt_phase),
      .nxt_idx   (nxt_idx)
   );

   fpg_decode #(
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN),
      .LO_FIRST  (LO_FIRST),
      .LO_LAST   (LO_LAST)
   ) u_dec (
      .phase   (nxt_phase),
      .idx     (nxt_idx),
      .start_d (start_d),
      .done_d  (done_d),
      .data_d  (data_d)
   );

   fpg_outreg #(.DATA_W(DATA_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .start_d (start_d),
      .done_d  (done_d),
      .data_d  (data_d),
      .start_q (start),
      .done_q  (done),
      .data_q  (data)
   );
endmodule

// File: rtl/fpg_check.sv
// Port-level checker: follows the frame from the observed start strobe.
module fpg_check #(
   parameter int DATA_W    = 8,
   parameter int FRAME_LEN = 64,
   parameter int LO_FIRST  = 24,
   parameter int LO_LAST   = 40
) (
   input logic              clk,
   input logic              rst,
   input logic              go,
   input logic              start,
   input logic [DATA_W-1:0] data,
   input logic              done
);
   localparam int POS_W = $clog2(FRAME_LEN + 1);
   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   logic             active;
   logic [POS_W-1:0] pos;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         pos    <= '0;
      end else if (start) begin
         active <= 1'b1;
         pos    <= POS_W'(1);
      end else if (active) begin
         if (pos == POS_W'(FRAME_LEN)) active <= 1'b0;
         else pos <= pos + 1'b1;
      end
   end

   a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!start && !done && data == '0));

   a_r2_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
      !active |-> (data == '0 && !done));

   a_r2_idle_no_start: assert property (@(posedge clk) disable iff (rst)
      (!active && !done && !$past(go)) |-> !start);

   a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
      start |=> !start);

   a_r3_start_data_zero: assert property (@(posedge clk) disable iff (rst)
      start |-> data == '0);

   a_r4_head_high: assert property (@(posedge clk) disable iff (rst)
      (active && pos >= POS_W'(1) && pos < POS_W'(LO_FIRST)) |-> data == ONES);

   a_r5_window_low: assert property (@(posedge clk) disable iff (rst)
      (active && pos >= POS_W'(LO_FIRST) && pos <= POS_W'(LO_LAST)) |-> data == '0);

   a_r6_tail_high: assert property (@(posedge clk) disable iff (rst)
      (active && pos > POS_W'(LO_LAST) && pos < POS_W'(FRAME_LEN)) |-> data == ONES);

   a_r7_done_slot: assert property (@(posedge clk) disable iff (rst)
      (active && pos == POS_W'(FRAME_LEN)) |-> (done && !start && data == '0));

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !start));

   a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (active && pos < POS_W'(FRAME_LEN)) |-> !start);
endmodule

bind frame_pattern_gen fpg_check #(
   .DATA_W    (DATA_W),
   .FRAME_LEN (FRAME_LEN),
   .LO_FIRST  (LO_FIRST),
   .LO_LAST   (LO_LAST)
) u_check (
   .clk   (clk),
   .rst   (rst),
   .go    (go),
   .start (start),
   .data  (data),
   .done  (done)
);

// File: tb/frame_pattern_gen_test.sv
module frame_pattern_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       go  = 1'b0;
   logic       start;
   logic [7:0] data;
   logic       done;

   int checks   = 0;
   int failures = 0;

   frame_pattern_gen uut (
      .clk   (clk),
      .rst   (rst),
      .go    (go),
      .start (start),
      .data  (data),
      .done  (done)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_data(input int k);
      return (k >= 1 && (k < 24 || k > 40)) ? 255 : 0;
   endfunction

   function automatic string data_tag(input int k);
      if (k == 0) return "R3 data at index 0";
      if (k < 24) return $sformatf("R4 data at index %0d", k);
      if (k <= 40) return $sformatf("R5 data at index %0d", k);
      return $sformatf("R6 data at index %0d", k);
   endfunction

   // Requires idle at a negedge. Ends at the negedge after the first idle cycle.
   task automatic run_frame(input bit keep_go, input bit poke);
      go = 1'b1;
      @(posedge clk);
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         chk($sformatf("R3 start at index %0d", k), int'(start), (k == 0) ? 1 : 0);
         chk(data_tag(k), int'(data), exp_data(k));
         chk("R7 done low inside frame", int'(done), 0);
         if (!keep_go) begin
            if (k == 0) go = 1'b0;
            if (poke && k == 10) go = 1'b1;   // R8 mid-frame request
            if (poke && k == 11) go = 1'b0;
         end
      end
      @(negedge clk);
      chk("R7 done after index 63", int'(done), 1);
      chk("R7 start low in done cycle", int'(start), 0);
      chk("R7 data zero in done cycle", int'(data), 0);
      if (poke) go = 1'b1;                     // R8 request inside done cycle
      @(negedge clk);
      chk("R7 done single cycle", int'(done), 0);
      chk("R8 no start after done cycle", int'(start), 0);
      chk("R7 data zero when idle", int'(data), 0);
      if (poke) begin
         go = 1'b0;
         @(negedge clk);
         chk("R8 request in done cycle not queued", int'(start), 0);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      go  = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 start after reset", int'(start), 0);
      chk("R1 data after reset", int'(data), 0);
      chk("R1 done after reset", int'(done), 0);
      go  = 1'b0;
      rst = 1'b0;
   endtask

   task automatic t_idle_quiet();
      go = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R2 idle start", int'(start), 0);
         chk("R2 idle data", int'(data), 0);
         chk("R2 idle done", int'(done), 0);
      end
   endtask

   task automatic t_single_frame();
      run_frame(1'b0, 1'b0);
   endtask

   task automatic t_ignored_requests();
      run_frame(1'b0, 1'b1);
   endtask

   task automatic t_back_to_back();
      int gap;
      run_frame(1'b1, 1'b0);
      // go still high: first idle cycle sampled it, next cycle is index 0
      @(negedge clk);
      chk("R9 second start follows held go", int'(start), 1);
      gap = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         gap++;
         if (start) break;
      end
      chk("R9 start spacing with held go", gap, 66);
      go = 1'b0;
      repeat (70) @(negedge clk);
      chk("R9 idle after releasing go", int'(start | done), 0);
      chk("R9 data zero after release", int'(data), 0);
   endtask

   task automatic t_reset_mid_frame();
      go = 1'b1;
      @(posedge clk);
      @(negedge clk);
      go = 1'b0;
      chk("R3 start before abort", int'(start), 1);
      repeat (5) @(negedge clk);
      chk("R4 data high before abort", int'(data), 255);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-frame reset clears data", int'(data), 0);
      chk("R1 mid-frame reset clears start", int'(start), 0);
      rst = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R1 idle after mid-frame reset", int'(data | {7'd0, start} | {7'd0, done}), 0);
      end
   endtask

   initial begin
      t_reset();
      t_idle_quiet();
      t_single_frame();
      t_idle_quiet();
      t_ignored_requests();
      t_back_to_back();
      t_reset_mid_frame();
      t_single_frame();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule